// File: doc/BRIEF.md
# Serial Port Clock and Frame-Sync Conditioner

This block sits between the pins of a synchronous serial port and the port's transmit and receive cores. It decides, for each side and each signal, whether the bit clock and the frame-sync come from a pin or from an internal sample-rate generator. It applies polarity inversion where the pin meets the internal logic, and it drives the output enable of each clock and frame-sync pin.

A fast system clock oversamples every pin through a synchronizer chain. The internal clock of each side is turned into one-cycle rising and falling strobes. The cores never have to deal with the external convention. Inside the block, frame-sync is always active high, transmit data is launched on the rising strobe, and receive data and frame-sync are captured on the falling strobe. The captured receive bit and the frame-sync flag appear in the same cycle as the falling strobe that sampled them.

The sample-rate generator is a separate block. Its clock and frame-sync levels reach this block as system-synchronous inputs. One generator clock is shared by both sides, and each side has its own generator frame-sync.

Top module: `sport_clkfs_cond`

## Requirements
- R1: A clock drive bit of 0 makes the side's internal clock follow the synchronized clock pin; a drive bit of 1 makes it follow `gen_clk`. The clock pin output enable equals the drive bit.
- R2: With the clock drive bit 0 and the clock invert bit 1, the internal clock is the inverse of the synchronized pin level, so a falling pin edge is an internal rising edge.
- R3: With the clock drive bit 1, the clock pin output equals `gen_clk` XOR the invert bit. With the drive bit 0, the clock pin output is 0.
- R4: A frame-sync drive bit of 0 takes the internal frame-sync from the synchronized frame-sync pin; a drive bit of 1 takes it from the side's generator frame-sync. The frame-sync pin output enable equals the drive bit.
- R5: With the frame-sync drive bit 0 and the invert bit 1, the internal frame-sync is the inverse of the synchronized pin level.
- R6: With the frame-sync drive bit 1, the frame-sync pin output equals the generator frame-sync XOR the invert bit, while the internal frame-sync stays uninverted. With the drive bit 0, the pin output is 0.
- R7: `rx_bit` takes the synchronized receive data level only on an internal falling edge of the receive clock, and it holds that value at all other times.
- R8: `rx_fs_det` and `tx_fs_det` take the internal frame-sync level of their own side on that side's internal falling clock edge. Each changes only in the cycle where that side's falling strobe is high.
- R9: Each internal clock edge gives exactly one single-cycle strobe: `*_rise_stb` for a rising edge (the transmit launch point) and `*_fall_stb` for a falling edge (the receive sample point). The two strobes of a side are never high together. When both sides use the generator clock with equal invert bits, the transmit rise strobe comes before the receive fall strobe.
- R10: A strobe goes high after the third system clock edge that follows a pin change (two synchronizer stages plus one edge register). For a change of `gen_clk`, the strobe goes high after the first such edge.
- R11: While `rst_n` is low at a clock edge, all strobes, `rx_bit` and both frame-sync flags clear to 0. With all configuration bits at 0, every pin output and output enable is 0.
- R12: Clock edges on one side produce no strobe and no capture on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_clk_drive | input | 1 | 1: receive clock comes from the generator and the pin is an output |
| rx_clk_invert | input | 1 | Receive clock polarity invert |
| rx_fs_drive | input | 1 | 1: receive frame-sync comes from the generator and the pin is an output |
| rx_fs_invert | input | 1 | Receive frame-sync polarity invert |
| tx_clk_drive | input | 1 | 1: transmit clock comes from the generator and the pin is an output |
| tx_clk_invert | input | 1 | Transmit clock polarity invert |
| tx_fs_drive | input | 1 | 1: transmit frame-sync comes from the generator and the pin is an output |
| tx_fs_invert | input | 1 | Transmit frame-sync polarity invert |
| gen_clk | input | 1 | Generator bit clock level (system-synchronous) |
| gen_rx_fs | input | 1 | Generator receive frame-sync, active high |
| gen_tx_fs | input | 1 | Generator transmit frame-sync, active high |
| rx_clk_pin_i | input | 1 | Receive clock pin input level |
| rx_fs_pin_i | input | 1 | Receive frame-sync pin input level |
| rx_data_pin_i | input | 1 | Receive data pin |
| tx_clk_pin_i | input | 1 | Transmit clock pin input level |
| tx_fs_pin_i | input | 1 | Transmit frame-sync pin input level |
| rx_clk_pin_o | output | 1 | Receive clock pin drive value |
| rx_clk_pin_oe | output | 1 | Receive clock pin output enable |
| rx_fs_pin_o | output | 1 | Receive frame-sync pin drive value |
| rx_fs_pin_oe | output | 1 | Receive frame-sync pin output enable |
| tx_clk_pin_o | output | 1 | Transmit clock pin drive value |
| tx_clk_pin_oe | output | 1 | Transmit clock pin output enable |
| tx_fs_pin_o | output | 1 | Transmit frame-sync pin drive value |
| tx_fs_pin_oe | output | 1 | Transmit frame-sync pin output enable |
| rx_rise_stb | output | 1 | Internal receive clock rising-edge strobe |
| rx_fall_stb | output | 1 | Internal receive clock falling-edge strobe (sample point) |
| rx_bit | output | 1 | Receive data captured at the last falling edge |
| rx_fs_det | output | 1 | Receive frame-sync level captured at the last falling edge |
| tx_rise_stb | output | 1 | Internal transmit clock rising-edge strobe (launch point) |
| tx_fall_stb | output | 1 | Internal transmit clock falling-edge strobe |
| tx_fs_det | output | 1 | Transmit frame-sync level captured at the last falling edge |

## Verification
The assertions assume that reset is held low for at least one clock edge before any check, and that configuration bits move only while the affected clock is quiet. They also assume that pin and generator levels stay put for several system cycles around each edge, so that a synchronized clock edge never lands in the same cycle as a data or frame-sync change. The stimulus follows these rules. It sets a vector's configuration and waits six cycles before it takes a strobe count. It changes data and frame-sync only while the clock is steady, and it holds each clock level for six cycles. Any strobe caused by a configuration change is therefore spent before the count starts.

// File: rtl/scc_pkg.sv
// Shared types for the serial port clock/frame-sync conditioner.
// Assumes: nothing; types only.
package scc_pkg;

    // Per-pin configuration: source selection and polarity.
    typedef struct packed {
        logic drive;   // 1: pin is an output fed from the generator
        logic invert;  // 1: pin polarity is inverted at the boundary
    } pin_cfg_t;

    // Registered edge strobes of one internal clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_stb_t;

    localparam int SYNC_STAGES_DEFAULT = 2;

endpackage

// File: rtl/scc_sync.sv
// Multi-bit synchronizer chain for asynchronous pin inputs.
// Assumes: each bit is treated on its own; STAGES >= 1; registers clear on reset.
module scc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pin levels through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/scc_pin_mux.sv
// Source select and polarity handling for one clock or frame-sync pin.
// Assumes: pin_sync is already synchronized; gen_level is system-synchronous.
// An input pin is inverted before internal use. The internal generator level
// is inverted before it drives an output pin. The output enable follows the
// drive bit.
module scc_pin_mux
    import scc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg,
    input  logic     pin_sync,
    input  logic     gen_level,
    output logic     int_level,
    output logic     pin_o,
    output logic     pin_oe
);

    // Internal level: generator when driving, conditioned pin otherwise.
    always_comb begin
        if (cfg.drive) int_level = gen_level;
        else           int_level = pin_sync ^ cfg.invert;
    end

    // Pin drive value: inverted generator level, parked low when an input.
    always_comb begin
        pin_oe = cfg.drive;
        pin_o  = cfg.drive ? (gen_level ^ cfg.invert) : 1'b0;
    end

    AST_PIN_MATCHES_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.drive |-> ((pin_o ^ cfg.invert) == int_level)); // R3

    AST_PIN_QUIET_AS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_o); // R6

endmodule

// File: rtl/scc_edge.sv
// Edge detector for one internal clock level in the system clock domain.
// Assumes: level is glitch-free at system-clock rate and stays put for at least two cycles per phase.
// Gives a combinational falling indication for same-edge capture and
// registered one-cycle rise/fall strobes.
module scc_edge
    import scc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    output logic      fall_now,
    output edge_stb_t stb
);

    logic prev_q;

    assign fall_now = prev_q & ~level;

    // Remember the previous level of the internal clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Register the rising and falling strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb <= '0;
        end else begin
            stb.rise <= level & ~prev_q;
            stb.fall <= fall_now;
        end
    end

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb.rise && stb.fall)); // R9

    AST_RISE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb.rise |=> !stb.rise); // R9

    AST_FALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb.fall |=> !stb.fall); // R9

endmodule

// File: rtl/scc_capture.sv
// Enable-gated capture flop for sampled levels.
// Assumes: en is a single-cycle indication computed in the same cycle as d.
module scc_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);

    // Load d on enable and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
    end

    AST_CAPTURE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> $past(en)); // R7

endmodule

// File: rtl/scc_side.sv
// One direction (receive or transmit) of the conditioner: clock and
// frame-sync pin handling, edge strobes, and frame-sync capture on the
// falling edge of the internal clock.
// Assumes: the generator levels are system-synchronous; pins are asynchronous.
module scc_side
    import scc_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t clk_cfg,
    input  pin_cfg_t fs_cfg,
    input  logic     clk_pin_i,
    input  logic     fs_pin_i,
    input  logic     gen_clk,
    input  logic     gen_fs,
    output logic     clk_pin_o,
    output logic     clk_pin_oe,
    output logic     fs_pin_o,
    output logic     fs_pin_oe,
    output logic     rise_stb,
    output logic     fall_stb,
    output logic     fall_now,
    output logic     fs_det
);

    localparam int PIN_W = 2;

    logic [PIN_W-1:0] pin_sync;
    logic             clk_int;
    logic             fs_int;
    edge_stb_t        stb;

    scc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fs_pin_i, clk_pin_i}),
        .q     (pin_sync)
    );

    scc_pin_mux u_clk_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (clk_cfg),
        .pin_sync  (pin_sync[0]),
        .gen_level (gen_clk),
        .int_level (clk_int),
        .pin_o     (clk_pin_o),
        .pin_oe    (clk_pin_oe)
    );

    scc_pin_mux u_fs_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (fs_cfg),
        .pin_sync  (pin_sync[1]),
        .gen_level (gen_fs),
        .int_level (fs_int),
        .pin_o     (fs_pin_o),
        .pin_oe    (fs_pin_oe)
    );

    scc_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (clk_int),
        .fall_now (fall_now),
        .stb      (stb)
    );

    assign rise_stb = stb.rise;
    assign fall_stb = stb.fall;

    scc_capture u_fs_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fall_now),
        .d     (fs_int),
        .q     (fs_det)
    );

    AST_FS_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fs_det) |-> fall_stb); // R8

endmodule

// File: rtl/sport_clkfs_cond.sv
// Top level of the serial port clock/frame-sync conditioner.
// Holds one receive side, one transmit side and the receive data sampling path.
// Assumes: configuration is static while the affected clock toggles; the
// generator clock is shared by both sides.
module sport_clkfs_cond
    import scc_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk_drive,
    input  logic rx_clk_invert,
    input  logic rx_fs_drive,
    input  logic rx_fs_invert,
    input  logic tx_clk_drive,
    input  logic tx_clk_invert,
    input  logic tx_fs_drive,
    input  logic tx_fs_invert,
    input  logic gen_clk,
    input  logic gen_rx_fs,
    input  logic gen_tx_fs,
    input  logic rx_clk_pin_i,
    input  logic rx_fs_pin_i,
    input  logic rx_data_pin_i,
    input  logic tx_clk_pin_i,
    input  logic tx_fs_pin_i,
    output logic rx_clk_pin_o,
    output logic rx_clk_pin_oe,
    output logic rx_fs_pin_o,
    output logic rx_fs_pin_oe,
    output logic tx_clk_pin_o,
    output logic tx_clk_pin_oe,
    output logic tx_fs_pin_o,
    output logic tx_fs_pin_oe,
    output logic rx_rise_stb,
    output logic rx_fall_stb,
    output logic rx_bit,
    output logic rx_fs_det,
    output logic tx_rise_stb,
    output logic tx_fall_stb,
    output logic tx_fs_det
);

    pin_cfg_t rx_clk_cfg, rx_fs_cfg, tx_clk_cfg, tx_fs_cfg;
    logic     rx_fall_now;
    logic     tx_fall_now;
    logic     rx_data_sync;

    // Pack the per-pin configuration bits.
    always_comb begin
        rx_clk_cfg = '{drive: rx_clk_drive, invert: rx_clk_invert};
        rx_fs_cfg  = '{drive: rx_fs_drive,  invert: rx_fs_invert};
        tx_clk_cfg = '{drive: tx_clk_drive, invert: tx_clk_invert};
        tx_fs_cfg  = '{drive: tx_fs_drive,  invert: tx_fs_invert};
    end

    scc_side #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_cfg    (rx_clk_cfg),
        .fs_cfg     (rx_fs_cfg),
        .clk_pin_i  (rx_clk_pin_i),
        .fs_pin_i   (rx_fs_pin_i),
        .gen_clk    (gen_clk),
        .gen_fs     (gen_rx_fs),
        .clk_pin_o  (rx_clk_pin_o),
        .clk_pin_oe (rx_clk_pin_oe),
        .fs_pin_o   (rx_fs_pin_o),
        .fs_pin_oe  (rx_fs_pin_oe),
        .rise_stb   (rx_rise_stb),
        .fall_stb   (rx_fall_stb),
        .fall_now   (rx_fall_now),
        .fs_det     (rx_fs_det)
    );

    scc_side #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_cfg    (tx_clk_cfg),
        .fs_cfg     (tx_fs_cfg),
        .clk_pin_i  (tx_clk_pin_i),
        .fs_pin_i   (tx_fs_pin_i),
        .gen_clk    (gen_clk),
        .gen_fs     (gen_tx_fs),
        .clk_pin_o  (tx_clk_pin_o),
        .clk_pin_oe (tx_clk_pin_oe),
        .fs_pin_o   (tx_fs_pin_o),
        .fs_pin_oe  (tx_fs_pin_oe),
        .rise_stb   (tx_rise_stb),
        .fall_stb   (tx_fall_stb),
        .fall_now   (tx_fall_now),
        .fs_det     (tx_fs_det)
    );

    // Receive data goes through the same stage count as the clock pin.
    scc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_data_pin_i),
        .q     (rx_data_sync)
    );

    scc_capture u_data_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_fall_now),
        .d     (rx_data_sync),
        .q     (rx_bit)
    );

    AST_RX_BIT_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit) |-> rx_fall_stb); // R7

    AST_TX_FS_IGNORES_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tx_fs_det) && !tx_fall_stb) |-> 1'b0); // R12

endmodule

// File: tb/sim_sport_clkfs_cond.sv
module sim_sport_clkfs_cond;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rx_clk_drive = 0, rx_clk_invert = 0, rx_fs_drive = 0, rx_fs_invert = 0;
    logic tx_clk_drive = 0, tx_clk_invert = 0, tx_fs_drive = 0, tx_fs_invert = 0;
    logic gen_clk = 0, gen_rx_fs = 0, gen_tx_fs = 0;
    logic rx_clk_pin_i = 0, rx_fs_pin_i = 0, rx_data_pin_i = 0, tx_clk_pin_i = 0, tx_fs_pin_i = 0;
    logic rx_clk_pin_o, rx_clk_pin_oe, rx_fs_pin_o, rx_fs_pin_oe;
    logic tx_clk_pin_o, tx_clk_pin_oe, tx_fs_pin_o, tx_fs_pin_oe;
    logic rx_rise_stb, rx_fall_stb, rx_bit, rx_fs_det, tx_rise_stb, tx_fall_stb, tx_fs_det;

    sport_clkfs_cond u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int rx_rise_n = 0, rx_fall_n = 0, tx_rise_n = 0, tx_fall_n = 0;
    logic cap_rx_bit = 0, cap_rx_fs = 0, cap_tx_fs = 0;

    // Field order of a vector, MSB first: side(1=tx) clk_drive clk_inv fs_drive fs_inv fs_level data
    localparam logic [6:0] VEC [16] = '{
        7'b0000011, 7'b0010010, 7'b0000111, 7'b0010101,
        7'b0101010, 7'b0111111, 7'b0100100, 7'b0011001,
        7'b1000010, 7'b1010000, 7'b1000100, 7'b1101010,
        7'b1111110, 7'b1110010, 7'b1011100, 7'b1001010
    };

    // Count strobes and record values presented with falling strobes.
    always @(negedge clk) begin
        if (rx_rise_stb) rx_rise_n++;
        if (tx_rise_stb) tx_rise_n++;
        if (rx_fall_stb) begin rx_fall_n++; cap_rx_bit = rx_bit; cap_rx_fs = rx_fs_det; end
        if (tx_fall_stb) begin tx_fall_n++; cap_tx_fs = tx_fs_det; end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        {rx_clk_drive, rx_clk_invert, rx_fs_drive, rx_fs_invert} = '0;
        {tx_clk_drive, tx_clk_invert, tx_fs_drive, tx_fs_invert} = '0;
        {gen_clk, gen_rx_fs, gen_tx_fs} = '0;
        {rx_clk_pin_i, rx_fs_pin_i, rx_data_pin_i, tx_clk_pin_i, tx_fs_pin_i} = '0;
    endtask

    // Drive the selected side's clock source so the internal level equals hi.
    task automatic set_clk(input bit side, input bit drv, input bit inv, input bit hi);
        if (drv) gen_clk = hi;
        else if (side) tx_clk_pin_i = hi ^ inv;
        else rx_clk_pin_i = hi ^ inv;
    endtask

    task automatic run_vec(input logic [6:0] v);
        bit side, cd, ci, fd, fi, fl, db, exp_fs;
        int rr0, rf0, tr0, tf0;
        {side, cd, ci, fd, fi, fl, db} = v;
        exp_fs = fd ? fl : (fl ^ fi);
        clear_all();
        if (side) {tx_clk_drive, tx_clk_invert, tx_fs_drive, tx_fs_invert} = {cd, ci, fd, fi};
        else      {rx_clk_drive, rx_clk_invert, rx_fs_drive, rx_fs_invert} = {cd, ci, fd, fi};
        set_clk(side, cd, ci, 1'b0);
        cycles(6);
        rr0 = rx_rise_n; rf0 = rx_fall_n; tr0 = tx_rise_n; tf0 = tx_fall_n;
        if (fd) begin if (side) gen_tx_fs = fl; else gen_rx_fs = fl; end
        else begin if (side) tx_fs_pin_i = fl; else rx_fs_pin_i = fl; end
        rx_data_pin_i = db;
        cycles(6);
        set_clk(side, cd, ci, 1'b1);
        cycles(6);
        // R1/R3/R4/R6 pin outputs while the internal clock is high
        check("R1", "clk_oe", side ? tx_clk_pin_oe : rx_clk_pin_oe, cd);
        check("R3", "clk_pin_o", side ? tx_clk_pin_o : rx_clk_pin_o, cd ? (1 ^ ci) : 0);
        check("R4", "fs_oe", side ? tx_fs_pin_oe : rx_fs_pin_oe, fd);
        check("R6", "fs_pin_o", side ? tx_fs_pin_o : rx_fs_pin_o, fd ? (fl ^ fi) : 0);
        check("R9", "rise_before_fall", side ? (tx_fall_n - tf0) : (rx_fall_n - rf0), 0);
        set_clk(side, cd, ci, 1'b0);
        cycles(6);
        // R2/R9 exactly one rise and one fall on the selected side
        check("R2", "rise_count", side ? (tx_rise_n - tr0) : (rx_rise_n - rr0), 1);
        check("R9", "fall_count", side ? (tx_fall_n - tf0) : (rx_fall_n - rf0), 1);
        // R12 other side untouched
        check("R12", "other_side_strobes",
              side ? (rx_rise_n - rr0 + rx_fall_n - rf0) : (tx_rise_n - tr0 + tx_fall_n - tf0), 0);
        // R5/R8 frame-sync level captured at the falling edge
        check(fd ? "R4" : "R5", "fs_captured", side ? cap_tx_fs : cap_rx_fs, exp_fs);
        if (!side) check("R7", "rx_bit_captured", cap_rx_bit, db);
    endtask

    initial begin
        clear_all();
        cycles(3);
        // R11 reset state
        check("R11", "strobes_in_reset", {rx_rise_stb, rx_fall_stb, tx_rise_stb, tx_fall_stb}, 0);
        check("R11", "captures_in_reset", {rx_bit, rx_fs_det, tx_fs_det}, 0);
        check("R11", "pins_in_reset", {rx_clk_pin_o, rx_clk_pin_oe, rx_fs_pin_o, rx_fs_pin_oe,
              tx_clk_pin_o, tx_clk_pin_oe, tx_fs_pin_o, tx_fs_pin_oe}, 0);
        rst_n = 1'b1;
        cycles(4);

        for (int i = 0; i < 16; i++) run_vec(VEC[i]);

        // R10 latency from a pin edge: strobe on the fourth falling sys edge
        clear_all();
        cycles(6);
        rx_clk_pin_i = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R10", $sformatf("pin_latency_slot%0d", k), rx_rise_stb, (k == 4) ? 1 : 0);
        end
        rx_clk_pin_i = 1'b0;
        cycles(6);

        // R10 latency from the generator clock: strobe after the first edge
        rx_clk_drive = 1'b1;
        cycles(6);
        gen_clk = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check("R10", $sformatf("gen_latency_slot%0d", k), rx_rise_stb, (k == 2) ? 1 : 0);
        end
        gen_clk = 1'b0;
        cycles(6);

        // R7 data change without a falling edge is ignored
        clear_all();
        rx_data_pin_i = 1'b1;
        rx_fs_pin_i = 1'b1;
        cycles(6);
        rx_clk_pin_i = 1'b1; cycles(6);
        rx_clk_pin_i = 1'b0; cycles(6);
        check("R7", "rx_bit_loaded", rx_bit, 1);
        rx_data_pin_i = 1'b0;
        rx_fs_pin_i = 1'b0;
        cycles(10);
        check("R7", "rx_bit_held", rx_bit, 1);
        check("R8", "rx_fs_held", rx_fs_det, 1);
        rx_clk_pin_i = 1'b1; cycles(6);
        check("R7", "rx_bit_held_on_rise", rx_bit, 1);
        rx_clk_pin_i = 1'b0; cycles(6);
        check("R7", "rx_bit_after_next_fall", rx_bit, 0);
        check("R8", "rx_fs_after_next_fall", rx_fs_det, 0);

        // R9 shared generator clock: transmit rise before receive fall
        clear_all();
        rx_clk_drive = 1'b1; tx_clk_drive = 1'b1;
        rx_clk_invert = 1'b1; tx_clk_invert = 1'b1;
        cycles(6);
        begin
            int tr0, rf0;
            tr0 = tx_rise_n; rf0 = rx_fall_n;
            gen_clk = 1'b1; cycles(6);
            check("R9", "shared_tx_rise", tx_rise_n - tr0, 1);
            check("R9", "shared_no_rx_fall_yet", rx_fall_n - rf0, 0);
            check("R3", "shared_pin_inverted", rx_clk_pin_o, 0);
            gen_clk = 1'b0; cycles(6);
            check("R9", "shared_rx_fall", rx_fall_n - rf0, 1);
        end

        // R11 reset clears captured values
        clear_all();
        rx_data_pin_i = 1'b1; tx_fs_pin_i = 1'b1;
        cycles(6);
        rx_clk_pin_i = 1'b1; tx_clk_pin_i = 1'b1; cycles(6);
        rx_clk_pin_i = 1'b0; tx_clk_pin_i = 1'b0; cycles(6);
        check("R11", "pre_reset_capture", {rx_bit, tx_fs_det}, 3);
        rst_n = 1'b0;
        cycles(2);
        check("R11", "reset_clears_capture", {rx_bit, rx_fs_det, tx_fs_det}, 0);
        rst_n = 1'b1;
        cycles(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule